// File: doc/BRIEF.md
# I/O Page Register Decoder

This block sits on the processor's data bus and serves every access whose 16-bit address lies in the top 8 KB, at octal 0160000 and above. It answers reads from a small set of system registers, fixed status constants and a window onto the processor's register file. It turns writes into update strobes for the status word, the stack limit and the register file, and into a character strobe for a console sink. It stores three registers of its own: the programmed interrupt request word, the line clock status word and the CPU error word.

Each access is a single cycle. The address, the size flag and a read or write strobe are presented, and read data, bus error and the update strobes come back combinationally in that same cycle. State held inside the block changes at the next clock edge. Addresses below the I/O page belong to memory, and the block ignores them. Any address in the I/O page that nothing here claims produces a bus-error pulse. This covers the address ranges of the tape, disk and terminal controllers, which are outside this block.

Top module: `iop_decoder`

## Requirements
- R1: An access to an address below octal 0160000 raises no bus error, drives no update strobe and returns read data 0.
- R2: A read of octal 0177750 returns 1. A read of octal 0177570, 0177514 or 0177564 returns 0x0080. A write to any of these four addresses is a bus error.
- R3: The status word sits at octal 0177776. A word write pulses psw_we_o with the full data. A byte write to 0177776 replaces bits 7:0 of psw_i, and a byte write to 0177777 replaces bits 15:8. The other byte is kept, and the new byte is always taken from wdata_i[7:0].
- R4: A byte read of a 16-bit register returns the addressed byte in rdata_o[7:0] with bits 15:8 zero. The even address gives bits 7:0 and the odd address gives bits 15:8. A word read returns all 16 bits.
- R5: The stack limit sits at octal 0177774 and follows the same word and byte rules as R3 and R4, through slim_i, slim_we_o and slim_wdata_o.
- R6: Octal 0177700–0177717 map to reg_idx_o = addr[3:0]. Indexes 0–5 are kernel R0–R5, 6 is kernel SP, 7 is PC, 8–13 are user R0–R5, 14 is supervisor SP and 15 is user SP. A word read returns reg_rdata_i, and a byte read returns its low byte. A word write pulses reg_we_o with wdata_i. A byte write there is a bus error.
- R7: The CPU error word sits at octal 0177766 and resets to 0. Bits set in err_set_i are ORed into it at each clock edge. Any write to it clears the old contents, whatever the data, while bits set in the same cycle still land.
- R8: The interrupt request word (octal 0177772) and the line clock status word (octal 0177546) are read/write storage. Both reset to 0 and follow the byte-merge rule of R3.
- R9: A write to octal 0177566 with a non-zero value pulses con_valid_o, with con_char_o set to the low 7 bits of that value. A zero value emits nothing. Neither case is a bus error, and a read of this address is a bus error.
- R10: A write to octal 0177746 raises no bus error and changes no strobe or stored register. A read of it is a bus error.
- R11: Any other I/O page access is a bus error and drives rdata_o to 0xFFFF. This includes a word access at an odd address outside the register window. A write that is not a bus error returns read data 0.
- R12: All outputs respond in the cycle of the strobe. bus_err_o and every update strobe are low whenever rd_i and wr_i are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (wins if both are high) |
| wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 16 | Read data, same cycle |
| bus_err_o | output | 1 | Unhandled access pulse |
| psw_i | input | 16 | Current status word |
| psw_we_o | output | 1 | Status word update strobe |
| psw_wdata_o | output | 16 | New status word |
| slim_i | input | 16 | Current stack limit |
| slim_we_o | output | 1 | Stack limit update strobe |
| slim_wdata_o | output | 16 | New stack limit |
| reg_idx_o | output | 4 | Register-file window index |
| reg_rdata_i | input | 16 | Register value at reg_idx_o |
| reg_we_o | output | 1 | Register-file write strobe |
| reg_wdata_o | output | 16 | Register-file write data |
| err_set_i | input | 16 | CPU error bits to set |
| con_valid_o | output | 1 | Console character strobe |
| con_char_o | output | 7 | Console character |

## Verification
Directed accesses first cover each claimed address with word reads, byte reads at both the even and the odd address, word writes and byte writes to both halves. These separate a swapped byte lane from a lost kept byte, and a constant register from storage. Zero and non-zero console writes separate the character filter from the decode. Writes to read-only registers, reads of write-only ones and odd word addresses separate a missing bus error from a spurious one. Random accesses then mix addresses from the claimed set, their odd neighbours, the whole I/O page and memory below it, while the status word, the stack limit and the error bits change every access. This exposes decode overlaps and byte-merge errors against a live background.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam logic [15:0] A_ONE     = 16'o177750;
  localparam logic [15:0] A_SWITCH  = 16'o177570;
  localparam logic [15:0] A_LPSTAT  = 16'o177514;
  localparam logic [15:0] A_CONSTAT = 16'o177564;
  localparam logic [15:0] A_CONBUF  = 16'o177566;
  localparam logic [15:0] A_PSW     = 16'o177776;
  localparam logic [15:0] A_SLIM    = 16'o177774;
  localparam logic [15:0] A_CPUERR  = 16'o177766;
  localparam logic [15:0] A_PIRQ    = 16'o177772;
  localparam logic [15:0] A_LCLK    = 16'o177546;
  localparam logic [15:0] A_CACHE   = 16'o177746;
  localparam logic [15:0] A_WINDOW  = 16'o177700;

  typedef enum logic [3:0] {
    T_NONE, T_BAD, T_ONE, T_C80, T_PSW, T_SLIM, T_WINDOW,
    T_CPUERR, T_PIRQ, T_LCLK, T_CACHE, T_CONBUF
  } tgt_e;

  localparam int unsigned PIDX_PIRQ = 0;
  localparam int unsigned PIDX_LCLK = 1;
  localparam int unsigned NPLAIN    = 2;

  function automatic logic [15:0] byte_merge(logic [15:0] old, logic [7:0] b, logic hi);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  function automatic logic [15:0] lane_pick(logic [15:0] v, logic byt, logic hi);
    if (!byt) return v;
    return hi ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
  endfunction

endpackage

// File: rtl/iop_decode.sv
module iop_decode
  import iop_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'o160000
) (
  input  logic [15:0] addr_i,
  input  logic        byte_i,
  input  logic        wr_i,
  output tgt_e        tgt_o
);

  logic [15:0] wa;
  assign wa = {addr_i[15:1], 1'b0};

  always_comb begin
    tgt_o = T_BAD;
    if (addr_i < IO_BASE) begin
      tgt_o = T_NONE;
    end else if (addr_i[15:4] == A_WINDOW[15:4]) begin
      tgt_o = (wr_i && byte_i) ? T_BAD : T_WINDOW;
    end else if (!byte_i && addr_i[0]) begin
      tgt_o = T_BAD;
    end else begin
      case (wa)
        A_ONE:                        tgt_o = wr_i ? T_BAD : T_ONE;
        A_SWITCH, A_LPSTAT, A_CONSTAT: tgt_o = wr_i ? T_BAD : T_C80;
        A_PSW:                        tgt_o = T_PSW;
        A_SLIM:                       tgt_o = T_SLIM;
        A_CPUERR:                     tgt_o = T_CPUERR;
        A_PIRQ:                       tgt_o = T_PIRQ;
        A_LCLK:                       tgt_o = T_LCLK;
        A_CACHE:                      tgt_o = wr_i ? T_CACHE : T_BAD;
        A_CONBUF:                     tgt_o = wr_i ? T_CONBUF : T_BAD;
        default:                      tgt_o = T_BAD;
      endcase
    end
  end

endmodule

// File: rtl/iop_sysregs.sv
module iop_sysregs
  import iop_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NP = NPLAIN
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NP-1:0]         plain_we_i,
  input  logic [NP-1:0][DW-1:0] plain_d_i,
  input  logic                  err_clr_i,
  input  logic [DW-1:0]         err_set_i,
  output logic [NP-1:0][DW-1:0] plain_q_o,
  output logic [DW-1:0]         err_q_o
);

  for (genvar g = 0; g < NP; g++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            plain_q_o[g] <= '0;
      else if (plain_we_i[g]) plain_q_o[g] <= plain_d_i[g];
    end
  end

  // clear drops old bits only; bits raised this cycle survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q_o <= '0;
    else         err_q_o <= (err_clr_i ? '0 : err_q_o) | err_set_i;
  end

endmodule

// File: rtl/iop_rdmux.sv
module iop_rdmux
  import iop_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  tgt_e          tgt_i,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          byte_i,
  input  logic          hi_i,
  input  logic [DW-1:0] psw_i,
  input  logic [DW-1:0] slim_i,
  input  logic [DW-1:0] win_i,
  input  logic [DW-1:0] err_i,
  input  logic [DW-1:0] pirq_i,
  input  logic [DW-1:0] lclk_i,
  output logic [DW-1:0] rdata_o
);

  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam logic [DW-1:0] V_ONE    = DW'(1);
  localparam logic [DW-1:0] V_C80    = DW'(16'h0080);

  logic [DW-1:0] sel;

  always_comb begin
    case (tgt_i)
      T_ONE:    sel = lane_pick(V_ONE, byte_i, hi_i);
      T_C80:    sel = lane_pick(V_C80, byte_i, hi_i);
      T_PSW:    sel = lane_pick(psw_i, byte_i, hi_i);
      T_SLIM:   sel = lane_pick(slim_i, byte_i, hi_i);
      T_CPUERR: sel = lane_pick(err_i, byte_i, hi_i);
      T_PIRQ:   sel = lane_pick(pirq_i, byte_i, hi_i);
      T_LCLK:   sel = lane_pick(lclk_i, byte_i, hi_i);
      T_WINDOW: sel = byte_i ? {8'h00, win_i[7:0]} : win_i;
      default:  sel = '0;
    endcase
    if (!act_i)              rdata_o = '0;
    else if (tgt_i == T_BAD) rdata_o = ALL_ONES;
    else if (rd_i)           rdata_o = sel;
    else                     rdata_o = '0;
  end

endmodule

// File: rtl/iop_decoder.sv
module iop_decoder
  import iop_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'o160000,
  parameter int unsigned CHAR_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              byte_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              bus_err_o,
  input  logic [15:0]       psw_i,
  output logic              psw_we_o,
  output logic [15:0]       psw_wdata_o,
  input  logic [15:0]       slim_i,
  output logic              slim_we_o,
  output logic [15:0]       slim_wdata_o,
  output logic [3:0]        reg_idx_o,
  input  logic [15:0]       reg_rdata_i,
  output logic              reg_we_o,
  output logic [15:0]       reg_wdata_o,
  input  logic [15:0]       err_set_i,
  output logic              con_valid_o,
  output logic [CHAR_W-1:0] con_char_o
);

  localparam int unsigned DW = 16;

  tgt_e                     tgt;
  logic                     act, wr_act, rd_act, hi;
  logic [DW-1:0]            con_val;
  logic [NPLAIN-1:0]        plain_we;
  logic [NPLAIN-1:0][DW-1:0] plain_d, plain_q;
  logic [DW-1:0]            pirq_q, lclk_q, err_q;
  logic                     err_clr;

  assign act    = rd_i | wr_i;
  assign wr_act = wr_i;
  assign rd_act = rd_i & ~wr_i;
  assign hi     = addr_i[0];

  iop_decode #(.IO_BASE(IO_BASE)) u_dec (
    .addr_i (addr_i),
    .byte_i (byte_i),
    .wr_i   (wr_i),
    .tgt_o  (tgt)
  );

  function automatic logic [DW-1:0] wr_value(logic [DW-1:0] old);
    return byte_i ? byte_merge(old, wdata_i[7:0], hi) : wdata_i;
  endfunction

  assign bus_err_o    = act && (tgt == T_BAD);

  assign psw_we_o     = wr_act && (tgt == T_PSW);
  assign psw_wdata_o  = wr_value(psw_i);
  assign slim_we_o    = wr_act && (tgt == T_SLIM);
  assign slim_wdata_o = wr_value(slim_i);

  assign reg_idx_o    = addr_i[3:0];
  assign reg_we_o     = wr_act && (tgt == T_WINDOW);
  assign reg_wdata_o  = wdata_i;

  assign con_val      = byte_i ? {8'h00, wdata_i[7:0]} : wdata_i;
  assign con_valid_o  = wr_act && (tgt == T_CONBUF) && (con_val != '0);
  assign con_char_o   = con_val[CHAR_W-1:0];

  assign plain_we[PIDX_PIRQ] = wr_act && (tgt == T_PIRQ);
  assign plain_we[PIDX_LCLK] = wr_act && (tgt == T_LCLK);
  assign pirq_q              = plain_q[PIDX_PIRQ];
  assign lclk_q              = plain_q[PIDX_LCLK];
  assign plain_d[PIDX_PIRQ]  = wr_value(pirq_q);
  assign plain_d[PIDX_LCLK]  = wr_value(lclk_q);
  assign err_clr             = wr_act && (tgt == T_CPUERR);

  iop_sysregs #(.DW(DW), .NP(NPLAIN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .plain_we_i (plain_we),
    .plain_d_i  (plain_d),
    .err_clr_i  (err_clr),
    .err_set_i  (err_set_i),
    .plain_q_o  (plain_q),
    .err_q_o    (err_q)
  );

  iop_rdmux #(.DW(DW)) u_rd (
    .tgt_i   (tgt),
    .act_i   (act),
    .rd_i    (rd_act),
    .byte_i  (byte_i),
    .hi_i    (hi),
    .psw_i   (psw_i),
    .slim_i  (slim_i),
    .win_i   (reg_rdata_i),
    .err_i   (err_q),
    .pirq_i  (pirq_q),
    .lclk_i  (lclk_q),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/iop_decoder_chk.sv
module iop_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        byte_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic        bus_err_o,
  input logic [15:0] psw_i,
  input logic        psw_we_o,
  input logic [15:0] psw_wdata_o,
  input logic        reg_we_o,
  input logic [15:0] err_set_i,
  input logic        con_valid_o,
  input logic [15:0] pirq_q,
  input logic [15:0] err_q
);

  assert_below_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 16'o160000) |-> (!bus_err_o && !psw_we_o && !reg_we_o && !con_valid_o));

  assert_one_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !byte_i && addr_i == 16'o177750) |-> (rdata_o == 16'd1 && !bus_err_o));

  assert_psw_high_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && byte_i && addr_i == 16'o177777) |->
      (psw_we_o && psw_wdata_o == {wdata_i[7:0], psw_i[7:0]}));

  assert_window_byte_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && byte_i && addr_i[15:4] == 12'hffc) |-> (bus_err_o && !reg_we_o));

  assert_err_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:1] == 15'h7ffb && (byte_i || !addr_i[0]) && err_set_i == 16'd0)
      |=> (err_q == 16'd0));

  assert_pirq_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !byte_i && addr_i == 16'o177772) |=> (pirq_q == $past(wdata_i)));

  assert_con_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !byte_i && addr_i == 16'o177566 && wdata_i == 16'd0) |-> !con_valid_o);

  assert_err_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (rdata_o == 16'hffff));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> (!bus_err_o && !psw_we_o && !reg_we_o && !con_valid_o));

endmodule

bind iop_decoder iop_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .byte_i      (byte_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .bus_err_o   (bus_err_o),
  .psw_i       (psw_i),
  .psw_we_o    (psw_we_o),
  .psw_wdata_o (psw_wdata_o),
  .reg_we_o    (reg_we_o),
  .err_set_i   (err_set_i),
  .con_valid_o (con_valid_o),
  .pirq_q      (pirq_q),
  .err_q       (err_q)
);

// File: tb/tb_iop_decoder.sv
`timescale 1ns/1ps
module tb_iop_decoder;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        byte_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic        bus_err_o;
  logic [15:0] psw_i = 16'h1234, psw_wdata_o;
  logic        psw_we_o;
  logic [15:0] slim_i = 16'h0400, slim_wdata_o;
  logic        slim_we_o;
  logic [3:0]  reg_idx_o;
  logic [15:0] reg_rdata_i, reg_wdata_o;
  logic        reg_we_o;
  logic [15:0] err_set_i = '0;
  logic        con_valid_o;
  logic [6:0]  con_char_o;

  int unsigned errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  function automatic logic [15:0] win_val(logic [3:0] i);
    return {i, 4'h5, ~i, 4'ha};
  endfunction
  assign reg_rdata_i = win_val(reg_idx_o);

  iop_decoder dut (.*);

  // bench model state
  logic [15:0] m_pirq = '0, m_lclk = '0, m_err = '0;
  logic [15:0] n_pirq, n_lclk, n_err;
  logic        e_err, e_psw_we, e_slim_we, e_reg_we, e_con;
  logic [15:0] e_rdata, e_psw_wd, e_slim_wd, e_reg_wd;
  logic [6:0]  e_char;
  string       e_req;

  function automatic logic [15:0] pick(logic [15:0] v, bit byt, bit hi);
    if (!byt) return v;
    return hi ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
  endfunction

  function automatic logic [15:0] put(logic [15:0] old, logic [15:0] wd, bit byt, bit hi);
    if (!byt) return wd;
    return hi ? {wd[7:0], old[7:0]} : {old[15:8], wd[7:0]};
  endfunction

  task automatic predict(bit rd, bit wr, bit byt, logic [15:0] a, logic [15:0] wd);
    logic [15:0] wa, cv;
    bit hi;
    wa = {a[15:1], 1'b0};
    hi = a[0];
    e_err = 0; e_rdata = '0; e_psw_we = 0; e_slim_we = 0; e_reg_we = 0; e_con = 0;
    e_psw_wd = 'x; e_slim_wd = 'x; e_reg_wd = 'x; e_char = 'x;
    n_pirq = m_pirq; n_lclk = m_lclk; n_err = m_err | err_set_i;
    e_req = "R11";
    if (a < 16'o160000) e_req = "R1";
    else if (a[15:4] == 12'hffc) begin
      e_req = "R6";
      if (wr) begin
        if (byt) e_err = 1; else begin e_reg_we = 1; e_reg_wd = wd; end
      end else e_rdata = byt ? {8'h00, win_val(a[3:0])[7:0]} : win_val(a[3:0]);
    end else if (!byt && hi) e_err = 1;
    else if (wa == 16'o177750) begin
      e_req = "R2"; if (wr) e_err = 1; else e_rdata = pick(16'd1, byt, hi);
    end else if (wa == 16'o177570 || wa == 16'o177514 || wa == 16'o177564) begin
      e_req = "R2"; if (wr) e_err = 1; else e_rdata = pick(16'h0080, byt, hi);
    end else if (wa == 16'o177776) begin
      e_req = byt ? "R4" : "R3";
      if (wr) begin e_req = "R3"; e_psw_we = 1; e_psw_wd = put(psw_i, wd, byt, hi); end
      else e_rdata = pick(psw_i, byt, hi);
    end else if (wa == 16'o177774) begin
      e_req = "R5";
      if (wr) begin e_slim_we = 1; e_slim_wd = put(slim_i, wd, byt, hi); end
      else e_rdata = pick(slim_i, byt, hi);
    end else if (wa == 16'o177766) begin
      e_req = "R7";
      if (wr) n_err = err_set_i; else e_rdata = pick(m_err, byt, hi);
    end else if (wa == 16'o177772) begin
      e_req = "R8";
      if (wr) n_pirq = put(m_pirq, wd, byt, hi); else e_rdata = pick(m_pirq, byt, hi);
    end else if (wa == 16'o177546) begin
      e_req = "R8";
      if (wr) n_lclk = put(m_lclk, wd, byt, hi); else e_rdata = pick(m_lclk, byt, hi);
    end else if (wa == 16'o177746) begin
      e_req = "R10"; if (!wr) e_err = 1;
    end else if (wa == 16'o177566) begin
      e_req = "R9";
      if (wr) begin
        cv = byt ? {8'h00, wd[7:0]} : wd;
        if (cv != 0) begin e_con = 1; e_char = cv[6:0]; end
      end else e_err = 1;
    end else e_err = 1;
    if (e_err) e_rdata = 16'hffff;
  endtask

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(bit rd, bit wr, bit byt, logic [15:0] a, logic [15:0] wd);
    @(negedge clk_i);
    rd_i = rd; wr_i = wr; byte_i = byt; addr_i = a; wdata_i = wd;
    #1;
    predict(rd, wr, byt, a, wd);
    #1;
    chk(e_req, "rdata", rdata_o, e_rdata);
    chk(e_req, "bus_err", {15'd0, bus_err_o}, {15'd0, e_err});
    chk(e_req, "psw_we", {15'd0, psw_we_o}, {15'd0, e_psw_we});
    if (e_psw_we) chk(e_req, "psw_wdata", psw_wdata_o, e_psw_wd);
    chk(e_req, "slim_we", {15'd0, slim_we_o}, {15'd0, e_slim_we});
    if (e_slim_we) chk(e_req, "slim_wdata", slim_wdata_o, e_slim_wd);
    chk(e_req, "reg_we", {15'd0, reg_we_o}, {15'd0, e_reg_we});
    if (e_reg_we) begin
      chk(e_req, "reg_wdata", reg_wdata_o, e_reg_wd);
      chk(e_req, "reg_idx", {12'd0, reg_idx_o}, {12'd0, a[3:0]});
    end
    chk(e_req, "con_valid", {15'd0, con_valid_o}, {15'd0, e_con});
    if (e_con) chk(e_req, "con_char", {9'd0, con_char_o}, {9'd0, e_char});
    @(posedge clk_i);
    #1;
    m_pirq = n_pirq; m_lclk = n_lclk; m_err = n_err;
    rd_i = 0; wr_i = 0; err_set_i = '0;
    #1;
    // R12: strobes drop with the access strobe
    chk("R12", "idle bus_err", {15'd0, bus_err_o}, 16'd0);
    chk("R12", "idle strobes", {13'd0, psw_we_o, reg_we_o, con_valid_o}, 16'd0);
  endtask

  function automatic logic [15:0] pool(int unsigned i);
    case (i)
      0: return 16'o177750;  1: return 16'o177570;  2: return 16'o177514;
      3: return 16'o177564;  4: return 16'o177566;  5: return 16'o177776;
      6: return 16'o177774;  7: return 16'o177766;  8: return 16'o177772;
      9: return 16'o177546; 10: return 16'o177746; 11: return 16'o177700;
     12: return 16'o177707; 13: return 16'o177713; 14: return 16'o177717;
     15: return 16'o172300; 16: return 16'o177560; default: return 16'o177777;
    endcase
  endfunction

  initial begin
    #(10ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // reset state
    op(1, 0, 0, 16'o177772, 0);   // R8 reset value
    op(1, 0, 0, 16'o177546, 0);   // R8
    op(1, 0, 0, 16'o177766, 0);   // R7
    // directed
    op(1, 0, 0, 16'o177750, 0);   // R2
    op(1, 0, 1, 16'o177570, 0);
    op(0, 1, 0, 16'o177564, 16'h5555);
    op(0, 1, 0, 16'o177776, 16'hbeef); // R3
    op(0, 1, 1, 16'o177776, 16'hff5a);
    op(0, 1, 1, 16'o177777, 16'h11c3);
    op(1, 0, 1, 16'o177777, 0);        // R4
    op(1, 0, 1, 16'o177776, 0);
    op(0, 1, 1, 16'o177775, 16'h0077); // R5
    op(1, 0, 0, 16'o177774, 0);
    op(1, 0, 0, 16'o177705, 0);        // R6
    op(1, 0, 1, 16'o177716, 0);
    op(0, 1, 0, 16'o177707, 16'h0200);
    op(0, 1, 1, 16'o177710, 16'h0001);
    err_set_i = 16'h0081;
    op(1, 0, 0, 16'o177700, 0);
    op(1, 0, 0, 16'o177766, 0);        // R7 accumulated
    err_set_i = 16'h0004;
    op(0, 1, 0, 16'o177766, 16'hffff); // clear, new bit lands
    op(1, 0, 0, 16'o177766, 0);
    op(0, 1, 0, 16'o177772, 16'hcafe); // R8
    op(0, 1, 1, 16'o177773, 16'h0012);
    op(1, 0, 0, 16'o177772, 0);
    op(0, 1, 1, 16'o177546, 16'h0040);
    op(1, 0, 0, 16'o177546, 0);
    op(0, 1, 0, 16'o177566, 16'h00c1); // R9
    op(0, 1, 0, 16'o177566, 16'h0000);
    op(0, 1, 1, 16'o177566, 16'h0100);
    op(1, 0, 0, 16'o177566, 0);
    op(0, 1, 0, 16'o177746, 16'h1234); // R10
    op(1, 0, 0, 16'o177772, 0);
    op(1, 0, 0, 16'o177746, 0);
    op(1, 0, 0, 16'o172540, 0);        // R11
    op(0, 1, 0, 16'o177561, 16'h0001);
    op(1, 0, 0, 16'o177777, 0);
    op(1, 0, 0, 16'o001000, 0);        // R1
    op(0, 1, 0, 16'o157776, 16'h1111);
    // random
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      bit w, b;
      case ($urandom % 4)
        0: a = pool($urandom % 18);
        1: a = pool($urandom % 18) | 16'd1;
        2: a = 16'o160000 + 16'($urandom % 8192);
        default: a = 16'($urandom % 16'o160000);
      endcase
      w = $urandom % 2;
      b = $urandom % 2;
      psw_i  = 16'($urandom);
      slim_i = 16'($urandom);
      err_set_i = ($urandom % 8 == 0) ? 16'($urandom) : 16'd0;
      op(!w, w, b, a, (($urandom % 6) == 0) ? 16'd0 : 16'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule